// File: doc/BRIEF.md
# DDR PHY Initialization Trigger and Status Poller

This block launches one initialization or training pass of a DDR PHY and waits for the pass to finish. The caller presents a step-select mask and pulses `start`. The block then acts as a register-bus master on an APB-style port. It writes the mask to the PHY control register with the trigger bit forced on. It waits a fixed number of configuration-clock cycles so that the PHY can begin. After that it reads the PHY status register repeatedly until that register shows completion or a training failure.

What goes into the mask is chosen by the caller. An initialization pass can ask for DLL soft reset, DLL lock, impedance calibration, interface timing reset, DRAM init and PHY-controller init, and adds DRAM reset only for DDR3 memory. A training pass asks for DQS-gate training, and adds read-valid training only when the memory is not DDR3. The block copies every mask bit to the PHY unchanged, except that it sets bit 0. When the pass ends, the block holds one of two results until the next accepted start: a completion flag together with a five-bit error vector, or a fatal timeout flag. A watchdog sets the timeout. Its cycle count is a parameter, sized for a wait of about one second.

Top module: `ddr_phy_init_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `timed_out`, `err_flags`, `psel` and `penable` are all 0.
- R2: A `start` pulse seen while idle causes exactly one write to address 0x004. The write data is `step_mask`, zero-extended, with bit 0 (the trigger bit) set. The write uses an APB setup cycle, then an access cycle that is held until `pready` is high.
- R3: The setup cycle of the first status read appears exactly SETTLE_CYCLES+1 cycles after the cycle in which the control write completed. That leaves SETTLE_CYCLES idle bus cycles between them.
- R4: Status reads go to address 0x010 and repeat until a read returns a word whose bit 0 (init done) or any of bits 9:5 is set. Bits 9:5 are, from bit 5 upward: gate-training error, gate-training intermittent error, DQS drift error, read-valid training error, and read-valid intermittent error. All other status bits are ignored.
- R5: When a status read ends the pass, `busy` falls and `done` rises together. `err_flags` then carries bits 9:5 of that final word.
- R6: `done`, `err_flags` and `timed_out` keep their values while the block is idle. They clear in the cycle after the next accepted start.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It produces no second write and leaves no pending pass.
- R8: If the pass has not ended after TIMEOUT_CYCLES busy cycles, `busy` falls and `timed_out` rises. `done` stays 0 and `err_flags` stays 0. The bus is released even if a transfer is stalled by `pready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin a pass |
| step_mask | input | MASK_W | Step-select bits to send to the PHY |
| busy | output | 1 | High from the first control-write cycle until the pass ends |
| done | output | 1 | Pass ended on a status read (held) |
| err_flags | output | 5 | Error bits from the final status read (held) |
| timed_out | output | 1 | Watchdog expired (held) |
| paddr | output | AW | Bus address |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus access phase |
| pwrite | output | 1 | Bus write strobe |
| pwdata | output | DW | Bus write data |
| prdata | input | DW | Bus read data |
| pready | input | 1 | Bus transfer-complete handshake |

## Verification
An accepted start shows up as `busy` and a write setup cycle one clock later. The first read setup comes SETTLE_CYCLES+1 clocks after the write's completing cycle. `done` and `err_flags` appear one clock after the ending read's `pready` cycle. On a timeout, `busy` has been high for exactly TIMEOUT_CYCLES cycles. The bench drives inputs and samples outputs on the falling edge, and it counts those falling edges from the relevant event. Each value is therefore compared on the exact cycle in which it is due, not merely eventually. A register-level PHY stub inserts wait states, returns a chosen number of not-finished words before the final word, and can stall the bus or the status word indefinitely.

// File: rtl/ddr_phy_init_seq.sv
module ddr_phy_init_seq #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int MASK_W = 16,
  parameter int SETTLE_CYCLES = 10,
  parameter int TIMEOUT_CYCLES = 100_000_000,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h004,
  parameter logic [AW-1:0] STAT_ADDR = 12'h010,
  parameter int TRIG_BIT = 0,
  parameter int DONE_BIT = 0,
  parameter int ERR_LSB = 5,
  parameter int NERR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MASK_W-1:0] step_mask,
  output logic              busy,
  output logic              done,
  output logic [NERR-1:0]   err_flags,
  output logic              timed_out,
  output logic [AW-1:0]     paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DW-1:0]     pwdata,
  input  logic [DW-1:0]     prdata,
  input  logic              pready
);

  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [DW-1:0] TRIG = DW'(1) << TRIG_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WACC, S_SETTLE, S_RSET, S_RACC
  } state_t;

  state_t          st;
  logic [DW-1:0]   wdata_q;
  logic [SW-1:0]   settle_q;
  logic [TW-1:0]   wdog_q;

  logic accept, stat_end, expire;
  logic [NERR-1:0] stat_err;
  logic unused_stat;

  assign accept   = (st == S_IDLE) && start;
  assign stat_err = prdata[ERR_LSB +: NERR];
  assign stat_end = (st == S_RACC) && pready && (prdata[DONE_BIT] || (|stat_err));
  assign expire   = busy && (wdog_q == TW'(TIMEOUT_CYCLES - 1)) && !stat_end;
  assign unused_stat = ^prdata;

  assign busy    = (st != S_IDLE);
  assign psel    = (st == S_WSET) || (st == S_WACC) || (st == S_RSET) || (st == S_RACC);
  assign penable = (st == S_WACC) || (st == S_RACC);
  assign pwrite  = (st == S_WSET) || (st == S_WACC);
  assign paddr   = pwrite ? CTRL_ADDR : STAT_ADDR;
  assign pwdata  = pwrite ? wdata_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wdata_q   <= '0;
      settle_q  <= '0;
      wdog_q    <= '0;
      done      <= 1'b0;
      err_flags <= '0;
      timed_out <= 1'b0;
    end else begin
      if (accept) wdog_q <= '0;
      else if (busy) wdog_q <= wdog_q + 1'b1;

      if (expire) begin
        st        <= S_IDLE;
        timed_out <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st        <= S_WSET;
            wdata_q   <= DW'(step_mask) | TRIG;
            done      <= 1'b0;
            err_flags <= '0;
            timed_out <= 1'b0;
          end
          S_WSET: st <= S_WACC;
          S_WACC: if (pready) begin
            st       <= S_SETTLE;
            settle_q <= '0;
          end
          S_SETTLE: begin
            settle_q <= settle_q + 1'b1;
            if (settle_q == SW'(SETTLE_CYCLES - 1)) st <= S_RSET;
          end
          S_RSET: st <= S_RACC;
          S_RACC: if (pready) begin
            if (stat_end) begin
              st        <= S_IDLE;
              done      <= 1'b1;
              err_flags <= stat_err;
            end else begin
              st <= S_RSET;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ddr_phy_init_seq_chk.sv
module ddr_phy_init_seq_chk #(
  parameter int AW = 12,
  parameter int SETTLE_CYCLES = 10,
  parameter int NERR = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h004,
  parameter logic [AW-1:0] STAT_ADDR = 12'h010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [NERR-1:0] err_flags,
  input logic            timed_out,
  input logic [AW-1:0]   paddr,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic            pready
);

  localparam int GW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [GW-1:0] GLIM = GW'(SETTLE_CYCLES + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= GLIM;
    else if (psel && penable && pwrite && pready) gap_q <= '0;
    else if (gap_q != GLIM) gap_q <= gap_q + 1'b1;
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !psel && !penable);

  assert_access_has_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);

  assert_write_only_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psel && pwrite) |-> $rose(busy) && paddr == CTRL_ADDR);

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> gap_q >= GW'(SETTLE_CYCLES) && paddr == STAT_ADDR);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done != timed_out);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy && $stable(done) && $stable(err_flags) && $stable(timed_out));

  assert_timeout_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !done && err_flags == '0);

endmodule

bind ddr_phy_init_seq ddr_phy_init_seq_chk #(
  .AW(AW), .SETTLE_CYCLES(SETTLE_CYCLES), .NERR(NERR),
  .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_flags(err_flags), .timed_out(timed_out), .paddr(paddr), .psel(psel),
  .penable(penable), .pwrite(pwrite), .pready(pready)
);

// File: tb/ddr_phy_init_seq_tb_top.sv
module ddr_phy_init_seq_tb_top;

  localparam int SETTLE = 10;
  localparam int TMO = 300;
  localparam int NV = 6;

  localparam logic [63:0] VEC [0:NV-1] = '{
    {16'h00F2, 4'd0, 4'd0, 8'h00, 32'h0000_0001},
    {16'h0140, 4'd2, 4'd3, 8'h00, 32'h0000_0001},
    {16'h0600, 4'd1, 4'd1, 8'h00, 32'h0000_0020},
    {16'hFFFF, 4'd0, 4'd2, 8'h00, 32'h0000_0201},
    {16'h0000, 4'd3, 4'd0, 8'h00, 32'h0000_03E0},
    {16'h0081, 4'd0, 4'd4, 8'h00, 32'hF000_0080}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] step_mask = '0;
  logic busy, done, timed_out, psel, penable, pwrite;
  logic [4:0] err_flags;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata = '0;
  logic pready = 1'b0;

  always #10 clk = ~clk;

  ddr_phy_init_seq #(.SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step_mask(step_mask),
    .busy(busy), .done(done), .err_flags(err_flags), .timed_out(timed_out),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .pready(pready));

  int checks = 0, failures = 0;
  int ws = 0, ws_cnt = 0, polls_before = 0;
  logic [31:0] fin = '0;
  bit hang_ready = 0, hang_status = 0;
  int n_wr = 0, n_rd = 0, n_badaddr = 0, cyc_since_wr = 0, gap_seen = 0;
  bit first_rd_pending = 0;
  logic [31:0] last_wdata = '0;
  logic [11:0] last_waddr = '0;

  always @(negedge clk) begin
    cyc_since_wr++;
    if (psel && !penable && !pwrite && first_rd_pending) begin
      gap_seen = cyc_since_wr;
      first_rd_pending = 0;
    end
    if (psel && penable && !hang_ready) begin
      if (ws_cnt == ws) begin
        pready = 1'b1;
        ws_cnt = 0;
        if (pwrite) begin
          n_wr++;
          last_wdata = pwdata;
          last_waddr = paddr;
          cyc_since_wr = 0;
          first_rd_pending = 1;
        end else begin
          if (paddr != 12'h010) n_badaddr++;
          prdata = (!hang_status && n_rd == polls_before) ? fin : 32'h0000_001E;
          n_rd++;
        end
      end else begin
        pready = 1'b0;
        ws_cnt++;
      end
    end else begin
      pready = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [15:0] m);
    n_wr = 0; n_rd = 0; n_badaddr = 0; ws_cnt = 0;
    gap_seen = -1; first_rd_pending = 0;
    @(negedge clk);
    start = 1'b1;
    step_mask = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(done == 1'b0 && timed_out == 1'b0 && err_flags == 5'd0, "R6",
        "flags cleared after start", {done, timed_out, err_flags}, 0);
  endtask

  task automatic wait_end(output int bcnt);
    bcnt = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
      bcnt++;
    end
  endtask

  initial begin
    int bc;
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 150000) begin
          @(posedge clk);
          wd++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(!busy && !done && !timed_out && err_flags == 0 && !psel && !penable, "R1",
        "reset state", {busy, done, timed_out, err_flags, psel, penable}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !psel, "R1", "idle after reset release", {busy, psel}, 0);

    for (int v = 0; v < NV; v++) begin
      ws = int'(VEC[v][47:44]);
      polls_before = int'(VEC[v][43:40]);
      fin = VEC[v][31:0];
      launch(VEC[v][63:48]);
      wait_end(bc);
      chk(n_wr == 1, "R2", "write count", n_wr, 1);
      chk(last_waddr == 12'h004, "R2", "write address", last_waddr, 12'h004);
      chk(last_wdata == ({16'h0, VEC[v][63:48]} | 32'h1), "R2", "write data",
          last_wdata, {16'h0, VEC[v][63:48]} | 32'h1);
      chk(gap_seen == SETTLE + 1, "R3", "settle gap", gap_seen, SETTLE + 1);
      chk(n_rd == polls_before + 1 && n_badaddr == 0, "R4", "status reads",
          n_rd, polls_before + 1);
      chk(done == 1'b1 && !timed_out, "R5", "done at end", {done, timed_out}, 2'b10);
      chk(err_flags == fin[9:5], "R5", "error flags", err_flags, fin[9:5]);
      repeat (15) @(negedge clk);
      chk(done == 1'b1 && err_flags == fin[9:5] && !busy, "R6", "held while idle",
          {busy, done, err_flags}, {1'b0, 1'b1, fin[9:5]});
    end

    ws = 1; polls_before = 3; fin = 32'h0000_0001;
    launch(16'h0030);
    repeat (3) @(negedge clk);
    start = 1'b1; step_mask = 16'hAAAA;
    @(negedge clk);
    start = 1'b0;
    wait_end(bc);
    repeat (6) @(negedge clk);
    chk(n_wr == 1 && last_wdata == 32'h0000_0031, "R7", "start while busy ignored",
        last_wdata, 32'h0000_0031);
    chk(!busy && done, "R7", "no queued pass", {busy, done}, 2'b01);

    ws = 0; hang_ready = 1;
    launch(16'h0010);
    wait_end(bc);
    chk(bc == TMO, "R8", "busy length stalled bus", bc, TMO);
    chk(timed_out && !done && err_flags == 0, "R8", "timeout flags stalled bus",
        {timed_out, done, err_flags}, 7'b1000000);
    chk(!psel && !penable, "R8", "bus released", {psel, penable}, 0);
    hang_ready = 0;

    hang_status = 1;
    launch(16'h0002);
    wait_end(bc);
    chk(bc == TMO, "R8", "busy length never done", bc, TMO);
    chk(timed_out && !done && err_flags == 0 && n_rd > 1, "R8", "timeout while polling",
        {timed_out, done, err_flags}, 7'b1000000);
    repeat (10) @(negedge clk);
    chk(timed_out && !busy, "R6", "timeout held", {timed_out, busy}, 2'b10);
    hang_status = 0;

    polls_before = 0; fin = 32'h0000_0001;
    launch(16'h0004);
    wait_end(bc);
    chk(done && !timed_out && err_flags == 0, "R6", "recovery after timeout",
        {done, timed_out, err_flags}, 7'b1000000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule